// File: doc/BRIEF.md
# Frame Receive Word Buffer with DMA Request

This block sits behind a single-wire serial receiver. It collects the decoded payload bytes of one frame and packs them into 32-bit words. A DMA engine moves those words to memory, one read of the data register per request. The receiver marks frame boundaries with one-cycle start and end strobes and qualifies each byte with a valid strobe.

At the end of a frame the block latches the payload byte count and raises a buffer-full flag. That flag can drive an interrupt. Software reads the length, then clears the flag with a write-one-to-clear pulse before the next frame is taken in. A word that completes while the data register is still unread waits in a one-word staging register. Bytes that arrive while the flag is still set are dropped and recorded as an overrun.

Top module: `frame_rx_dma_buf`

## Requirements
- R1: The block takes bytes and strobes, and raises requests, only while `dmaEnable`=1 and `bufferMode`=0. Otherwise bytes, start and end strobes are ignored and `dmaReq` stays 0.
- R2: Bytes are packed little-endian. The first byte of each word goes to bits 7:0, the second to 15:8, the third to 23:16 and the fourth to 31:24.
- R3: `dmaReq` is 1 exactly while an unread word is held in `rdData` and the block is in the mode of R1. It is 0 after reset.
- R4: A cycle with `wordRead`=1 while `dmaReq`=1 consumes the word. `rdAck` is 1 in the following cycle. The next waiting word, if any, appears in that same following cycle. While a word is held and not read, `rdData` does not change.
- R5: A word that completes while `rdData` holds an unread word is kept in a staging register and moves to `rdData` after the read. If both are occupied and no read occurs, the new word is lost and `overrun` is set.
- R6: A frame carries at most 32 payload bytes (8 words). Further bytes of the frame are ignored and the count stays at 32.
- R7: A frame-end strobe pushes any partial word with its unused upper bytes zero. One cycle later it sets `fullFlag` and loads `payloadLen` with the frame's byte count. `payloadLen` changes at no other time.
- R8: `irq` is 1 exactly when `fullFlag`=1 and `irqEnable`=1.
- R9: A cycle with `fullClear`=1 clears `fullFlag` and `overrun` in the next cycle, unless a new overrun event occurs in that same cycle.
- R10: While `fullFlag`=1, arriving bytes are discarded and set `overrun`. A frame end is also ignored, so `payloadLen` keeps the earlier count.
- R11: A frame-start strobe clears the byte count and the packing position and discards a partial word. When strobes coincide, start wins over end, and end wins over a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Payload byte strobe |
| byteData | input | 8 | Payload byte |
| frameStart | input | 1 | Start-of-frame strobe |
| frameEnd | input | 1 | End-of-frame strobe |
| dmaEnable | input | 1 | DMA reception enable |
| bufferMode | input | 1 | Receive-mode select, 0 selects single-buffer DMA |
| irqEnable | input | 1 | Buffer-full interrupt enable |
| wordRead | input | 1 | DMA read of the data register |
| fullClear | input | 1 | Write-one-to-clear of buffer-full and overrun |
| rdData | output | 32 | Read data register |
| rdAck | output | 1 | Acknowledge, one cycle after an accepted read |
| dmaReq | output | 1 | DMA request |
| fullFlag | output | 1 | Receive buffer full |
| overrun | output | 1 | Byte or word lost |
| irq | output | 1 | Interrupt |
| payloadLen | output | 6 | Payload byte count of the last frame |

## Verification
The embedded properties assume the receiver never pulses a start or end strobe in the same cycle as a byte. They also assume the frame-end strobe is the only way the buffer-full flag can rise. The stimulus keeps every strobe to a single cycle, separated by idle cycles. The modelled DMA engine reads only while the request is high, so the read-consumes property rests on reads that are always legal. Mode changes happen only between frames, which keeps the hold-while-unread property meaningful.

// File: rtl/frb_pkg.sv
package frb_pkg;
  localparam int unsigned WordW        = 32;
  localparam int unsigned ByteW        = 8;
  localparam int unsigned LanesPerWord = WordW / ByteW;
  localparam int unsigned LaneW        = $clog2(LanesPerWord);

  typedef logic [LaneW-1:0] lane_t;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic  restart;
    logic  acceptByte;
    lane_t lane;
    logic  wordDone;
    logic  loadFromStage;
    logic  loadFromNew;
    logic  stageLoadNew;
    logic  lenLoad;
  } dp_ctrl_t;
endpackage

// File: rtl/frb_ctrl.sv
module frb_ctrl
  import frb_pkg::*;
#(
  parameter int unsigned FRAME_WORDS = 8,
  localparam int unsigned MaxBytes = FRAME_WORDS * LanesPerWord,
  localparam int unsigned LenW = $clog2(MaxBytes + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            byteValid,
  input  logic            frameStart,
  input  logic            frameEnd,
  input  logic            dmaEnable,
  input  logic            bufferMode,
  input  logic            wordRead,
  input  logic            fullClear,
  output dp_ctrl_t        ctrl,
  output logic [LenW-1:0] byteCount,
  output logic            dmaReq,
  output logic            rdAck,
  output logic            fullFlag,
  output logic            overrun
);
  logic  active, closeFrame, byteReq, dropByte, readNow, drain, wordLost;
  logic  readyFlag, stageValid;
  lane_t lane;

  always_comb begin
    active     = dmaEnable & ~bufferMode;
    byteReq    = active & byteValid & ~frameStart & ~frameEnd;
    closeFrame = active & frameEnd & ~frameStart & ~fullFlag;
    dropByte   = byteReq & fullFlag;
    dmaReq     = readyFlag & active;
    readNow    = wordRead & dmaReq;
    drain      = ~readyFlag | readNow;

    ctrl.restart    = active & frameStart;
    ctrl.acceptByte = byteReq & ~fullFlag & (byteCount < LenW'(MaxBytes));
    ctrl.lane       = lane;
    ctrl.wordDone   = (ctrl.acceptByte & (lane == lane_t'(LanesPerWord - 1)))
                    | (closeFrame & (lane != '0));
    ctrl.loadFromStage = stageValid & drain;
    ctrl.loadFromNew   = ctrl.wordDone & ~stageValid & drain;
    ctrl.stageLoadNew  = ctrl.wordDone & (stageValid ? drain : ~drain);
    ctrl.lenLoad       = closeFrame;
    wordLost = ctrl.wordDone & stageValid & ~drain;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lane       <= '0;
      byteCount  <= '0;
      readyFlag  <= 1'b0;
      stageValid <= 1'b0;
      fullFlag   <= 1'b0;
      overrun    <= 1'b0;
      rdAck      <= 1'b0;
    end else begin
      if (ctrl.restart || closeFrame) begin
        lane      <= '0;
        byteCount <= '0;
      end else if (ctrl.acceptByte) begin
        lane      <= lane + 1'b1;
        byteCount <= byteCount + 1'b1;
      end
      readyFlag  <= (readyFlag & ~readNow) | ctrl.loadFromStage | ctrl.loadFromNew;
      stageValid <= (stageValid & ~drain) | ctrl.stageLoadNew;
      if (closeFrame)         fullFlag <= 1'b1;
      else if (fullClear)     fullFlag <= 1'b0;
      if (dropByte || wordLost) overrun <= 1'b1;
      else if (fullClear)       overrun <= 1'b0;
      rdAck <= readNow;
    end
  end

  a_r4_read_consumes: assert property (@(posedge clk) disable iff (!rstN)
    readNow && !stageValid && !ctrl.wordDone |=> !readyFlag);
  a_r5_stage_behind_data: assert property (@(posedge clk) disable iff (!rstN)
    stageValid |-> readyFlag);
  a_r6_count_cap: assert property (@(posedge clk) disable iff (!rstN)
    byteCount <= LenW'(MaxBytes));
  a_r7_full_from_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullFlag) |-> $past(frameEnd));
  a_r9_clear_full: assert property (@(posedge clk) disable iff (!rstN)
    fullClear && fullFlag |=> !fullFlag);
  a_r10_drop_overrun: assert property (@(posedge clk) disable iff (!rstN)
    dropByte |=> overrun);
endmodule

// File: rtl/frb_datapath.sv
module frb_datapath
  import frb_pkg::*;
#(
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ByteW-1:0] byteData,
  input  dp_ctrl_t         ctrl,
  input  logic [LEN_W-1:0] byteCount,
  output logic [WordW-1:0] rdData,
  output logic [LEN_W-1:0] payloadLen
);
  logic [WordW-1:0] packReg, newWord, stageReg;

  always_comb begin
    newWord = packReg;
    if (ctrl.acceptByte) newWord[ctrl.lane*ByteW +: ByteW] = byteData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      packReg    <= '0;
      stageReg   <= '0;
      rdData     <= '0;
      payloadLen <= '0;
    end else begin
      if (ctrl.restart || ctrl.wordDone) packReg <= '0;
      else if (ctrl.acceptByte)          packReg <= newWord;
      if (ctrl.stageLoadNew) stageReg <= newWord;
      if (ctrl.loadFromStage)    rdData <= stageReg;
      else if (ctrl.loadFromNew) rdData <= newWord;
      if (ctrl.lenLoad) payloadLen <= byteCount;
    end
  end

  a_r11_restart_clears_pack: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.restart |=> packReg == '0);
  a_r7_len_latch: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.lenLoad |=> payloadLen == $past(byteCount));
  a_r7_len_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.lenLoad |=> $stable(payloadLen));
endmodule

// File: rtl/frame_rx_dma_buf.sv
module frame_rx_dma_buf
  import frb_pkg::*;
#(
  parameter int unsigned FRAME_WORDS = 8,
  localparam int unsigned LenW = $clog2(FRAME_WORDS * LanesPerWord + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic [ByteW-1:0] byteData,
  input  logic             frameStart,
  input  logic             frameEnd,
  input  logic             dmaEnable,
  input  logic             bufferMode,
  input  logic             irqEnable,
  input  logic             wordRead,
  input  logic             fullClear,
  output logic [WordW-1:0] rdData,
  output logic             rdAck,
  output logic             dmaReq,
  output logic             fullFlag,
  output logic             overrun,
  output logic             irq,
  output logic [LenW-1:0]  payloadLen
);
  dp_ctrl_t        ctrl;
  logic [LenW-1:0] byteCount;

  frb_ctrl #(.FRAME_WORDS(FRAME_WORDS)) ctrl_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .frameStart(frameStart),
    .frameEnd(frameEnd), .dmaEnable(dmaEnable), .bufferMode(bufferMode),
    .wordRead(wordRead), .fullClear(fullClear), .ctrl(ctrl),
    .byteCount(byteCount), .dmaReq(dmaReq), .rdAck(rdAck),
    .fullFlag(fullFlag), .overrun(overrun)
  );

  frb_datapath #(.LEN_W(LenW)) dp_i (
    .clk(clk), .rstN(rstN), .byteData(byteData), .ctrl(ctrl),
    .byteCount(byteCount), .rdData(rdData), .payloadLen(payloadLen)
  );

  assign irq = fullFlag & irqEnable;

  a_r4_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq && !wordRead |=> $stable(rdData));
  a_r4_ack_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    rdAck |-> $past(wordRead));
endmodule

// File: tb/frame_rx_dma_buf_tb.sv
module frame_rx_dma_buf_tb_top;
  localparam int ClkPeriod = 10;
  localparam int MaxB = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 0, frameStart = 0, frameEnd = 0;
  logic dmaEnable = 0, bufferMode = 0, irqEnable = 0, fullClear = 0;
  logic wordRead = 0;
  logic [7:0] byteData = 0;
  logic [31:0] rdData;
  logic rdAck, dmaReq, fullFlag, overrun, irq;
  logic [5:0] payloadLen;

  int nChecks = 0, nFail = 0;
  bit dmaGo = 0;
  logic [31:0] got[$];

  always #(ClkPeriod/2) clk = ~clk;

  frame_rx_dma_buf dut_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .frameStart(frameStart), .frameEnd(frameEnd), .dmaEnable(dmaEnable),
    .bufferMode(bufferMode), .irqEnable(irqEnable), .wordRead(wordRead),
    .fullClear(fullClear), .rdData(rdData), .rdAck(rdAck), .dmaReq(dmaReq),
    .fullFlag(fullFlag), .overrun(overrun), .irq(irq), .payloadLen(payloadLen)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0]  curB[$];
  logic [31:0] outQ[$];
  int mCount = 0, mLen = 0;
  bit mFull = 0, mOvr = 0, mAck = 0;

  function automatic logic [31:0] packQ(input logic [7:0] q[$]);
    logic [31:0] w = '0;
    foreach (q[i]) w[8*i +: 8] = q[i];
    return w;
  endfunction

  always @(posedge clk) begin
    bit act, oldFull, rd, haveWord;
    int s;
    logic [31:0] w;
    if (!rstN) begin
      curB.delete(); outQ.delete();
      mCount = 0; mLen = 0; mFull = 0; mOvr = 0; mAck = 0;
    end else begin
      act = dmaEnable && !bufferMode;
      oldFull = mFull;
      s = outQ.size();
      rd = wordRead && act && s > 0;
      haveWord = 0;
      w = '0;
      mAck = rd;
      if (fullClear) begin mFull = 0; mOvr = 0; end
      if (act && frameStart) begin
        curB.delete(); mCount = 0;
      end else if (act && frameEnd) begin
        if (!oldFull) begin
          if (curB.size() > 0) begin w = packQ(curB); haveWord = 1; end
          mFull = 1; mLen = mCount; curB.delete(); mCount = 0;
        end
      end else if (act && byteValid) begin
        if (oldFull) mOvr = 1;
        else if (mCount < MaxB) begin
          curB.push_back(byteData); mCount++;
          if (curB.size() == 4) begin w = packQ(curB); haveWord = 1; curB.delete(); end
        end
      end
      if (rd) void'(outQ.pop_front());
      if (haveWord) begin
        if (s == 2 && !rd) mOvr = 1;
        else outQ.push_back(w);
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit expReq;
    #3;
    if (rstN) begin
      expReq = dmaEnable && !bufferMode && outQ.size() > 0;
      check(dmaReq == expReq, "R3 request", 32'(dmaReq), 32'(expReq));
      if (expReq) check(rdData == outQ[0], "R2 word data", rdData, outQ[0]);
      check(rdAck == mAck, "R4 ack", 32'(rdAck), 32'(mAck));
      check(fullFlag == mFull, "R7 full flag", 32'(fullFlag), 32'(mFull));
      check(payloadLen == 6'(mLen), "R7 length", 32'(payloadLen), 32'(mLen));
      check(irq == (mFull && irqEnable), "R8 irq", 32'(irq), 32'(mFull && irqEnable));
      check(overrun == mOvr, "R10 overrun", 32'(overrun), 32'(mOvr));
    end
  end

  // DMA engine model
  always @(negedge clk) begin
    #1;
    wordRead = dmaGo && dmaReq;
    if (wordRead) got.push_back(rdData);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic settle();
    @(negedge clk); #4;
  endtask
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); byteValid = 1; byteData = b;
    @(negedge clk); byteValid = 0;
  endtask
  task automatic pulseStart();
    @(negedge clk); frameStart = 1; @(negedge clk); frameStart = 0;
  endtask
  task automatic pulseEnd();
    @(negedge clk); frameEnd = 1; @(negedge clk); frameEnd = 0;
  endtask
  task automatic pulseClear();
    @(negedge clk); fullClear = 1; @(negedge clk); fullClear = 0;
  endtask
  task automatic sendFrame(input int n, input logic [7:0] base);
    pulseStart();
    for (int i = 0; i < n; i++) sendByte(base + 8'(i));
    pulseEnd();
    idle(6);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", nChecks - nFail + 1, nChecks + 1);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1;
    settle();
    check(dmaReq == 0 && fullFlag == 0 && irq == 0, "R3 reset outputs", 32'(dmaReq), 0);
    check(payloadLen == 0 && overrun == 0, "R7 reset length", 32'(payloadLen), 0);

    // R1: inactive modes ignore everything
    dmaGo = 1;
    sendFrame(6, 8'h01);
    dmaEnable = 1; bufferMode = 1;
    sendFrame(5, 8'h01);
    settle();
    check(fullFlag == 0 && dmaReq == 0 && got.size() == 0, "R1 inactive", 32'(fullFlag), 0);

    // R2, R7: ten-byte frame, last word zero-padded
    bufferMode = 0; irqEnable = 1;
    got.delete();
    sendFrame(10, 8'h11);
    settle();
    check(got.size() == 3, "R7 word count", got.size(), 3);
    if (got.size() == 3) begin
      check(got[0] == 32'h14131211, "R2 little-endian", got[0], 32'h14131211);
      check(got[2] == 32'h00001a19, "R7 zero pad", got[2], 32'h00001a19);
    end
    check(payloadLen == 10 && irq == 1, "R8 irq with length 10", 32'(payloadLen), 10);

    // R10: bytes while full are dropped
    sendFrame(4, 8'h80);
    settle();
    check(overrun == 1 && payloadLen == 10, "R10 drop while full", 32'(payloadLen), 10);
    // R9: clear
    pulseClear();
    settle();
    check(fullFlag == 0 && overrun == 0, "R9 clear", 32'(fullFlag), 0);

    // R8: interrupt masked
    irqEnable = 0;
    sendFrame(4, 8'h21);
    settle();
    check(fullFlag == 1 && irq == 0 && payloadLen == 4, "R8 masked", 32'(irq), 0);
    pulseClear();

    // R5: staging with stalled DMA, third word lost
    dmaGo = 0; got.delete();
    sendFrame(12, 8'h40);
    settle();
    check(overrun == 1 && dmaReq == 1, "R5 staging overrun", 32'(overrun), 1);
    dmaGo = 1;
    idle(6);
    check(got.size() == 2, "R5 two words kept", got.size(), 2);
    if (got.size() == 2) check(got[1] == 32'h47464544, "R5 staged word", got[1], 32'h47464544);
    pulseClear();

    // R6: oversize frame
    got.delete();
    sendFrame(36, 8'h00);
    settle();
    check(payloadLen == 32 && got.size() == 8, "R6 length cap", 32'(payloadLen), 32);
    pulseClear();

    // R11: restart mid-frame
    got.delete();
    pulseStart();
    for (int i = 0; i < 3; i++) sendByte(8'hc0 + 8'(i));
    pulseStart();
    sendByte(8'hd0); sendByte(8'hd1);
    pulseEnd();
    idle(4);
    settle();
    check(payloadLen == 2, "R11 restart length", 32'(payloadLen), 2);
    if (got.size() == 1) check(got[0] == 32'h0000d1d0, "R11 restart word", got[0], 32'h0000d1d0);
    else check(0, "R11 restart word count", got.size(), 1);
    pulseClear();
    idle(4);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule